// File: doc/BRIEF.md
# Serial Debug Port Command Shifter

This block links an external development tool to a processor core over one serial input and one serial output. Each outbound transmission opens with a low ready bit, which tells the tool that the core is waiting for input. The ready bit is followed by a two-bit status and, when the status carries core data, a 32-bit word. Once the tool has seen the ready bit it sends one inbound frame. That frame holds a start bit, a mode bit, a control bit and a 32-bit payload.

The mode and control bits select what the frame does. It can hand an instruction to the core, hand data to the core, load a seven-bit trap-enable register, or run a port command. The commands clear breakpoint requests, pulse a core reset, or switch fast download on or off, and any other code does nothing. A frame whose kind does not match what the core expects is dropped and reported as a sequence error. Outgoing status is ranked by priority so that core data is never delayed by an interrupt report.

Serial timing is one bit per rising edge of `clk`. Payloads and data words travel most significant bit first.

Top module: `sdp_debug_port`

## Requirements
- R1: After reset `sdo` is 1, `trap_en` is 0, `fdl_en` is 0, and no status is pending, so the first outbound transmission carries status 11 (null).
- R2: An outbound transmission starts only while `core_req` is 1 and the inbound frame answering the previous transmission has been consumed. It is a 0 ready bit, then status MSB first, then 32 data bits MSB first only when the status is 00. `sdo` is 1 at all other times.
- R3: An inbound frame is a 1 start bit, then mode, then control, then the 32-bit payload MSB first. Start bits are ignored unless a ready bit has been sent since the last accepted frame.
- R4: Mode 0 and control 0 while `core_want_data` is 0 pulse `core_ins_vld` for one cycle with the payload on `core_word`, two cycles after the last frame bit is sampled.
- R5: Mode 0 and control 1 while `core_want_data` is 1 pulse `core_dat_vld` for one cycle with the payload on `core_word`, at the same timing.
- R6: An instruction frame while `core_want_data` is 1, or a data frame while it is 0, forwards nothing to the core and makes status 01 (sequence error) pending.
- R7: Mode 1 and control 0 load `trap_en` from payload bits 31..25. The other payload bits have no effect.
- R8: Mode 1 and control 1 decode payload bits 31..25 as a command: 0011111 pulses `brk_clr`, 0000001 pulses `cpu_rst`, 0000010 sets `fdl_en`, 0000011 clears `fdl_en`. All other codes, including 0000000, change nothing.
- R9: A `core_wr_vld` pulse captures `core_wr_data` and makes status 00 pending. The next transmission then carries that word.
- R10: Pending statuses are sent in the order 00 before 01 before 10 before 11. A status that is not chosen stays pending for a later transmission, so an interrupt arriving together with core data is reported in the transmission after the data.
- R11: An `irq_evt` pulse makes status 10 (interrupt) pending until it is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sdi | input | 1 | Serial frames from the tool |
| sdo | output | 1 | Serial transmissions to the tool |
| core_req | input | 1 | Core is waiting for an instruction or data |
| core_want_data | input | 1 | 1: core expects data, 0: core expects an instruction |
| core_wr_vld | input | 1 | Core moves a word into the port data register |
| core_wr_data | input | 32 | Word from the core |
| irq_evt | input | 1 | Interrupt recognised |
| core_ins_vld | output | 1 | Instruction delivered to the core |
| core_dat_vld | output | 1 | Data delivered to the core |
| core_word | output | 32 | Delivered instruction or data |
| trap_en | output | 7 | Trap-enable control register |
| brk_clr | output | 1 | Pulse: negate breakpoint requests |
| cpu_rst | output | 1 | Pulse: reset the processor |
| fdl_en | output | 1 | Fast download enabled |

## Verification
The assertions assume that the tool never starts an inbound frame before it has seen a ready bit. They also assume that `sdi` rests at 0 between frames and that `core_want_data` stays steady while a frame is arriving. The stimulus drives `sdi` only from a frame task that runs after an outbound transmission has been fully received, or on purpose while `core_req` is low to show that an unrequested frame is ignored. Core-side pulses are raised between frames so that each one lands at a known point.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  localparam int CMD_W = 7;

  localparam logic [CMD_W-1:0] CMD_BRK_CLR = 7'b0011111;
  localparam logic [CMD_W-1:0] CMD_RESET   = 7'b0000001;
  localparam logic [CMD_W-1:0] CMD_FDL_ON  = 7'b0000010;
  localparam logic [CMD_W-1:0] CMD_FDL_OFF = 7'b0000011;

  typedef enum logic [1:0] {
    ST_DATA = 2'b00,
    ST_SEQ  = 2'b01,
    ST_IRQ  = 2'b10,
    ST_NULL = 2'b11
  } sdp_stat_e;

  typedef enum logic [1:0] {
    FK_INSN = 2'b00,
    FK_DATA = 2'b01,
    FK_TRAP = 2'b10,
    FK_CMD  = 2'b11
  } frame_kind_e;

  typedef enum logic [2:0] {
    OP_NOP,
    OP_BRK,
    OP_RST,
    OP_FON,
    OP_FOFF
  } cmd_op_e;

  function automatic frame_kind_e frame_kind(input logic mode, input logic ctl);
    return frame_kind_e'({mode, ctl});
  endfunction

  function automatic cmd_op_e decode_cmd(input logic [CMD_W-1:0] code);
    cmd_op_e op;
    case (code)
      CMD_BRK_CLR: op = OP_BRK;
      CMD_RESET:   op = OP_RST;
      CMD_FDL_ON:  op = OP_FON;
      CMD_FDL_OFF: op = OP_FOFF;
      default:     op = OP_NOP;
    endcase
    return op;
  endfunction

  function automatic sdp_stat_e pick_status(input logic dv, input logic se, input logic ir);
    if (dv)      return ST_DATA;
    else if (se) return ST_SEQ;
    else if (ir) return ST_IRQ;
    return ST_NULL;
  endfunction

endpackage

// File: rtl/sdp_rx_shifter.sv
module sdp_rx_shifter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  input  logic              arm,
  output logic              frm_vld,
  output logic              frm_mode,
  output logic              frm_ctl,
  output logic [DATA_W-1:0] frm_pay
);
  localparam int FW = DATA_W + 2;
  localparam int CW = $clog2(FW + 1);

  logic          busy;
  logic [CW-1:0] cnt;
  logic [FW-1:0] sh;
  logic [FW-1:0] frm_q;
  logic          last_bit;

  assign last_bit = busy && (cnt == CW'(FW - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      frm_q   <= '0;
      frm_vld <= 1'b0;
    end else begin
      frm_vld <= last_bit;
      if (!busy) begin
        if (arm && !frm_vld && sdi) begin
          busy <= 1'b1;
          cnt  <= '0;
        end
      end else begin
        sh  <= {sh[FW-2:0], sdi};
        cnt <= cnt + 1'b1;
        if (last_bit) begin
          busy  <= 1'b0;
          frm_q <= {sh[FW-2:0], sdi};
        end
      end
    end
  end

  assign frm_mode = frm_q[FW-1];
  assign frm_ctl  = frm_q[FW-2];
  assign frm_pay  = frm_q[DATA_W-1:0];

  a_r3_frame_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld |=> !frm_vld);

endmodule

// File: rtl/sdp_decode.sv
module sdp_decode import sdp_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int TRAP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_vld,
  input  logic              frm_mode,
  input  logic              frm_ctl,
  input  logic [DATA_W-1:0] frm_pay,
  input  logic              core_want_data,
  output logic              seq_evt,
  output logic              core_ins_vld,
  output logic              core_dat_vld,
  output logic [DATA_W-1:0] core_word,
  output logic [TRAP_W-1:0] trap_en,
  output logic              brk_clr,
  output logic              cpu_rst,
  output logic              fdl_en
);
  frame_kind_e fk;
  cmd_op_e     op;
  logic        ins_ok, dat_ok, trap_ld, cmd_hit;

  assign fk      = frame_kind(frm_mode, frm_ctl);
  assign op      = decode_cmd(frm_pay[DATA_W-1 -: CMD_W]);
  assign ins_ok  = frm_vld && (fk == FK_INSN) && !core_want_data;
  assign dat_ok  = frm_vld && (fk == FK_DATA) &&  core_want_data;
  assign seq_evt = frm_vld && (((fk == FK_INSN) &&  core_want_data) ||
                               ((fk == FK_DATA) && !core_want_data));
  assign trap_ld = frm_vld && (fk == FK_TRAP);
  assign cmd_hit = frm_vld && (fk == FK_CMD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_ins_vld <= 1'b0;
      core_dat_vld <= 1'b0;
      core_word    <= '0;
      trap_en      <= '0;
      brk_clr      <= 1'b0;
      cpu_rst      <= 1'b0;
      fdl_en       <= 1'b0;
    end else begin
      core_ins_vld <= ins_ok;
      core_dat_vld <= dat_ok;
      if (ins_ok || dat_ok) core_word <= frm_pay;
      if (trap_ld) trap_en <= frm_pay[DATA_W-1 -: TRAP_W];
      brk_clr <= cmd_hit && (op == OP_BRK);
      cpu_rst <= cmd_hit && (op == OP_RST);
      if (cmd_hit && (op == OP_FON))       fdl_en <= 1'b1;
      else if (cmd_hit && (op == OP_FOFF)) fdl_en <= 1'b0;
    end
  end

  a_r4_one_delivery: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_ins_vld, core_dat_vld, brk_clr, cpu_rst}));
  a_r6_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
    seq_evt |=> !core_ins_vld && !core_dat_vld);
  a_r7_trap_by_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(trap_en) |-> $past(frm_vld));
  a_r8_fdl_by_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fdl_en) |-> $past(frm_vld));

endmodule

// File: rtl/sdp_status_arb.sv
module sdp_status_arb import sdp_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dat_wr,
  input  logic [DATA_W-1:0] dat_in,
  input  logic              seq_evt,
  input  logic              irq_evt,
  input  logic              tx_start,
  output sdp_stat_e         sel,
  output logic [DATA_W-1:0] dat_q,
  output logic              dv_pend,
  output logic              se_pend,
  output logic              ir_pend
);
  logic take_dv, take_se, take_ir;

  assign sel     = pick_status(dv_pend, se_pend, ir_pend);
  assign take_dv = tx_start && (sel == ST_DATA);
  assign take_se = tx_start && (sel == ST_SEQ);
  assign take_ir = tx_start && (sel == ST_IRQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dv_pend <= 1'b0;
      se_pend <= 1'b0;
      ir_pend <= 1'b0;
      dat_q   <= '0;
    end else begin
      dv_pend <= (dv_pend && !take_dv) || dat_wr;
      se_pend <= (se_pend && !take_se) || seq_evt;
      ir_pend <= (ir_pend && !take_ir) || irq_evt;
      if (dat_wr) dat_q <= dat_in;
    end
  end

  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr |=> dv_pend);
  a_r11_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && ir_pend && sel != ST_IRQ) |=> ir_pend);
  a_r6_seq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && se_pend && sel == ST_DATA) |=> se_pend);

endmodule

// File: rtl/sdp_tx_shifter.sv
module sdp_tx_shifter import sdp_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  sdp_stat_e         stat,
  input  logic [DATA_W-1:0] dat,
  output logic              busy,
  output logic              sdo
);
  localparam int TW = DATA_W + 3;
  localparam int CW = $clog2(TW + 1);

  logic [TW-1:0] sh;
  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '0;
      left <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      sh   <= {1'b0, stat, dat};
      left <= (stat == ST_DATA) ? CW'(TW) : CW'(3);
    end else if (busy) begin
      sh   <= {sh[TW-2:0], 1'b0};
      left <= left - 1'b1;
      if (left == CW'(1)) busy <= 1'b0;
    end
  end

  assign sdo = busy ? sh[TW-1] : 1'b1;

  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sdo);
  a_r2_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !sdo);

endmodule

// File: rtl/sdp_debug_port.sv
module sdp_debug_port import sdp_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int TRAP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sdi,
  output logic              sdo,
  input  logic              core_req,
  input  logic              core_want_data,
  input  logic              core_wr_vld,
  input  logic [DATA_W-1:0] core_wr_data,
  input  logic              irq_evt,
  output logic              core_ins_vld,
  output logic              core_dat_vld,
  output logic [DATA_W-1:0] core_word,
  output logic [TRAP_W-1:0] trap_en,
  output logic              brk_clr,
  output logic              cpu_rst,
  output logic              fdl_en
);
  logic              armed, tx_busy, tx_start;
  logic              frm_vld, frm_mode, frm_ctl, seq_evt;
  logic [DATA_W-1:0] frm_pay, dat_q;
  logic              dv_pend, se_pend, ir_pend;
  sdp_stat_e         tx_stat;

  assign tx_start = !armed && !tx_busy && core_req;

  always_ff @(posedge clk) begin
    if (!rst_n)        armed <= 1'b0;
    else if (tx_start) armed <= 1'b1;
    else if (frm_vld)  armed <= 1'b0;
  end

  sdp_rx_shifter #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .arm(armed),
    .frm_vld(frm_vld), .frm_mode(frm_mode), .frm_ctl(frm_ctl), .frm_pay(frm_pay)
  );

  sdp_decode #(.DATA_W(DATA_W), .TRAP_W(TRAP_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm_mode(frm_mode),
    .frm_ctl(frm_ctl), .frm_pay(frm_pay), .core_want_data(core_want_data),
    .seq_evt(seq_evt), .core_ins_vld(core_ins_vld), .core_dat_vld(core_dat_vld),
    .core_word(core_word), .trap_en(trap_en), .brk_clr(brk_clr),
    .cpu_rst(cpu_rst), .fdl_en(fdl_en)
  );

  sdp_status_arb #(.DATA_W(DATA_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .dat_wr(core_wr_vld), .dat_in(core_wr_data),
    .seq_evt(seq_evt), .irq_evt(irq_evt), .tx_start(tx_start),
    .sel(tx_stat), .dat_q(dat_q), .dv_pend(dv_pend), .se_pend(se_pend),
    .ir_pend(ir_pend)
  );

  sdp_tx_shifter #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .stat(tx_stat), .dat(dat_q),
    .busy(tx_busy), .sdo(sdo)
  );

  a_r3_frame_when_armed: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld |-> armed);
  a_r2_one_turn: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> armed);
  a_r10_data_first: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && dv_pend) |-> (tx_stat == ST_DATA));
  a_r10_seq_before_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start && !dv_pend && se_pend && ir_pend) |=> ir_pend);

endmodule

// File: tb/sim_sdp_debug_port.sv
module sim_sdp_debug_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sdi = 1'b0;
  logic        core_req = 1'b0;
  logic        core_want_data = 1'b0;
  logic        core_wr_vld = 1'b0;
  logic [31:0] core_wr_data = '0;
  logic        irq_evt = 1'b0;
  logic        sdo, core_ins_vld, core_dat_vld, brk_clr, cpu_rst, fdl_en;
  logic [31:0] core_word;
  logic [6:0]  trap_en;

  always #10 clk = ~clk;

  sdp_debug_port u0 (
    .clk(clk), .rst_n(rst_n), .sdi(sdi), .sdo(sdo), .core_req(core_req),
    .core_want_data(core_want_data), .core_wr_vld(core_wr_vld),
    .core_wr_data(core_wr_data), .irq_evt(irq_evt), .core_ins_vld(core_ins_vld),
    .core_dat_vld(core_dat_vld), .core_word(core_word), .trap_en(trap_en),
    .brk_clr(brk_clr), .cpu_rst(cpu_rst), .fdl_en(fdl_en)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // pulse counters seen at the ports
  int c_ins = 0, c_dat = 0, c_brk = 0, c_rst = 0;
  logic [31:0] last_word = '0;
  always @(posedge clk) begin
    if (core_ins_vld) begin c_ins++; last_word = core_word; end
    if (core_dat_vld) begin c_dat++; last_word = core_word; end
    if (brk_clr) c_brk++;
    if (cpu_rst) c_rst++;
  end

  // behavioural reference state
  int e_ins = 0, e_dat = 0, e_brk = 0, e_rst = 0;
  logic [31:0] e_word = '0;
  logic [6:0]  e_trap = '0;
  bit          e_fdl = 0;
  bit          m_dv = 0, m_se = 0, m_ir = 0;
  logic [31:0] m_data = '0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_port(string req);
    check(req, c_ins, e_ins);
    check(req, c_dat, e_dat);
    check(req, c_brk, e_brk);
    check(req, c_rst, e_rst);
    check(req, last_word, e_word);
    check(req, trap_en, e_trap);
    check(req, fdl_en, e_fdl);
  endtask

  // send one inbound frame; accept says whether the port should act on it
  task automatic send(bit mode, bit ctl, logic [31:0] pay, bit accept, string req);
    logic [34:0] f = {1'b1, mode, ctl, pay};
    for (int i = 34; i >= 0; i--) begin
      @(negedge clk) sdi = f[i];
    end
    @(negedge clk) sdi = 1'b0;
    @(negedge clk);
    @(negedge clk);
    if (accept) begin
      case ({mode, ctl})
        2'b00: if (!core_want_data) begin e_ins++; e_word = pay; end else m_se = 1;
        2'b01: if (core_want_data) begin e_dat++; e_word = pay; end else m_se = 1;
        2'b10: e_trap = pay[31:25];
        default: case (pay[31:25])
          7'b0011111: e_brk++;
          7'b0000001: e_rst++;
          7'b0000010: e_fdl = 1;
          7'b0000011: e_fdl = 0;
          default: ;
        endcase
      endcase
    end
    check_port(req);
  endtask

  // receive one outbound transmission and compare with the model
  task automatic get_tx(string req);
    logic [1:0]  st;
    logic [31:0] d = '0;
    logic [1:0]  e_st;
    int          guard = 0;
    while (sdo !== 1'b0 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check({req, " ready"}, sdo, 1'b0);
    if (m_dv) begin e_st = 2'b00; m_dv = 0; end
    else if (m_se) begin e_st = 2'b01; m_se = 0; end
    else if (m_ir) begin e_st = 2'b10; m_ir = 0; end
    else e_st = 2'b11;
    for (int i = 1; i >= 0; i--) begin
      @(negedge clk) st[i] = sdo;
    end
    check({req, " status"}, st, e_st);
    if (st == 2'b00) begin
      for (int i = 31; i >= 0; i--) begin
        @(negedge clk) d[i] = sdo;
      end
      check({req, " data"}, d, m_data);
    end
    @(negedge clk);
    check({req, " idle high"}, sdo, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 sdo", sdo, 1'b1);
    check("R1 trap", trap_en, '0);
    check("R1 fdl", fdl_en, 1'b0);
    repeat (3) @(negedge clk);
    check("R2 no req no tx", sdo, 1'b1);
    core_req = 1'b1;
    get_tx("R1 first null");

    // R4 instruction delivery
    send(0, 0, 32'h1234_5678, 1, "R4 insn");
    get_tx("R2 after insn");
    // R5 data delivery
    core_want_data = 1'b1;
    send(0, 1, 32'hCAFE_F00D, 1, "R5 data");
    get_tx("R2 after data");
    // R6 instruction while data expected
    send(0, 0, 32'hDEAD_0001, 1, "R6 mismatch insn");
    get_tx("R6 seq report");
    core_want_data = 1'b0;
    send(0, 1, 32'hDEAD_0002, 1, "R6 mismatch data");
    get_tx("R6 seq report 2");

    // R7 trap-enable load, low payload bits ignored
    send(1, 0, 32'hAB00_0123, 1, "R7 trap");
    get_tx("R7 after trap");

    // R8 commands
    send(1, 1, 32'h0400_0000, 1, "R8 fdl on");
    get_tx("R8 tx");
    send(1, 1, 32'h3E00_0000, 1, "R8 brk clr");
    get_tx("R8 tx");
    send(1, 1, 32'h0200_0000, 1, "R8 cpu rst");
    get_tx("R8 tx");
    send(1, 1, 32'h8000_0000, 1, "R8 unlisted code");
    get_tx("R8 tx");
    send(1, 1, 32'h0000_FFFF, 1, "R8 nop");
    get_tx("R8 tx");
    send(1, 1, 32'h0600_0000, 1, "R8 fdl off");
    get_tx("R8 tx");

    // R9 R10 core data with simultaneous interrupt
    @(negedge clk);
    core_wr_vld = 1'b1; core_wr_data = 32'h5A5A_00FF; irq_evt = 1'b1;
    @(negedge clk);
    core_wr_vld = 1'b0; irq_evt = 1'b0;
    m_dv = 1; m_data = 32'h5A5A_00FF; m_ir = 1;
    send(1, 1, 32'h0, 1, "R10 nop");
    get_tx("R9 valid data first");
    send(1, 1, 32'h0, 1, "R10 nop");
    get_tx("R11 held interrupt");
    send(1, 1, 32'h0, 1, "R10 nop");
    get_tx("R10 null after drain");

    // R10 sequence error ranks above interrupt
    @(negedge clk) irq_evt = 1'b1;
    @(negedge clk) irq_evt = 1'b0;
    m_ir = 1;
    send(0, 1, 32'h0BAD_0BAD, 1, "R6 mismatch with irq");
    get_tx("R10 seq before irq");
    send(1, 1, 32'h0, 1, "R10 nop");
    get_tx("R11 irq after seq");

    // R3 unrequested frame ignored
    core_req = 1'b0;
    send(1, 1, 32'h0, 1, "R3 last accepted");
    check("R2 no tx without req", sdo, 1'b1);
    send(1, 0, 32'hFE00_0000, 0, "R3 ignored trap");
    check("R3 sdo quiet", sdo, 1'b1);
    core_req = 1'b1;
    get_tx("R2 tx resumes");

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule